// File: doc/BRIEF.md
# Pin Interrupt Trigger Evaluator

This block watches one sampled serial input line and decides whether a change on it should raise an interrupt. Each time a fresh sample arrives (marked by a one-cycle strobe), the block compares it with the value it stored from the previous strobe. It then qualifies the result with an enable bit and a three-bit trigger code. The code can select falling edge, rising edge, level-low, level-high or dual-edge.

A qualifying event sets a sticky status flag. On the same clock edge it produces a one-cycle set pulse. A parent that gathers many pins can count that pulse as one pending event. Software-facing logic elsewhere clears the flag through a plain clear input. A set arriving in the same cycle as a clear takes priority, so an event is never lost.

Level modes are judged only when the sample really changes value. A strobe that repeats the stored value never fires, whatever the mode.

Top module: `pin_irq_trigger`

## Requirements
- R1: After reset, `irq_status` and `irq_set_pulse` are 0 and the stored previous sample is 0. A first strobe with level 1 is therefore a rising change.
- R2: With `trig_code` = 3'b000 (falling edge), a strobe that moves the sample from 1 to 0 fires. A move from 0 to 1 does not fire.
- R3: With `trig_code` = 3'b001 (rising edge), a strobe that moves the sample from 0 to 1 fires. A move from 1 to 0 does not fire.
- R4: With `trig_code` = 3'b010 (level-low), a strobe that changes the sample and leaves it at 0 fires.
- R5: With `trig_code` = 3'b011 (level-high), a strobe that changes the sample and leaves it at 1 fires.
- R6: Any `trig_code` with bit 2 set (3'b100 to 3'b111) selects dual-edge: every change in either direction fires. Bits 1:0 are ignored.
- R7: While `int_en` is 0, nothing fires: `irq_set_pulse` stays 0 and `irq_status` is never set.
- R8: Nothing fires on a cycle without `sample_strobe`, or on a strobe whose level equals the stored previous sample. This holds in every mode, including the level modes.
- R9: Once set, `irq_status` stays 1 until `status_clr` is asserted.
- R10: `status_clr` drives `irq_status` to 0 on the next edge, whether or not it was set, unless a set arrives in the same cycle.
- R11: When a qualifying event and `status_clr` occur in the same cycle, `irq_status` is 1 afterwards.
- R12: Every qualifying event gives exactly one cycle of `irq_set_pulse`, visible on the same edge that sets `irq_status`. This holds even when the flag was already 1.
- R13: The stored previous sample follows every strobe, whether `int_en` is set or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| int_en | input | 1 | Interrupt enable for this pin |
| trig_code | input | 3 | Trigger mode code (see R2 to R6) |
| sample_strobe | input | 1 | One-cycle mark that `sample_level` holds a fresh sample |
| sample_level | input | 1 | Newly sampled line value |
| status_clr | input | 1 | Clear request for the sticky flag |
| irq_status | output | 1 | Sticky interrupt status flag |
| irq_set_pulse | output | 1 | One-cycle pulse per qualifying event |

## Verification
The bench builds the block with the trigger code width left at three bits. This puts all eight codes within reach, including the four aliases that the dual-edge top bit produces. With the previous-sample reset value fixed at 0, the very first strobe becomes a deterministic rising change. The same-cycle set and clear, and repeated events on an already-set flag, are both reachable directly.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int TRIG_W = 3;
  localparam int BASE_W = TRIG_W - 1;

  // Low bits of the trigger code, used when the top bit is clear.
  typedef enum logic [BASE_W-1:0] {
    MODE_FALL = 2'b00,
    MODE_RISE = 2'b01,
    MODE_LOW  = 2'b10,
    MODE_HIGH = 2'b11
  } base_mode_e;

  typedef struct packed {
    logic rise;
    logic fall;
    logic now_high;
  } edge_info_t;
endpackage

// File: rtl/pin_edge_track.sv
module pin_edge_track
  import pin_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic       level,
  output edge_info_t info,
  output logic       changed
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else if (strobe) prev_q <= level;
  end

  always_comb begin
    info.rise     = strobe & level & ~prev_q;
    info.fall     = strobe & ~level & prev_q;
    info.now_high = level;
    changed       = info.rise | info.fall;
  end

  // R13: the stored sample follows every strobe
  assert_prev_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (prev_q == $past(level)));
  // R8: a stored sample holds while no strobe arrives
  assert_prev_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(prev_q));
endmodule

// File: rtl/pin_trig_decode.sv
module pin_trig_decode
  import pin_irq_pkg::*;
(
  input  logic              int_en,
  input  logic [TRIG_W-1:0] trig_code,
  input  edge_info_t        info,
  input  logic              changed,
  output logic              hit
);
  base_mode_e base;
  logic       dual;
  logic       qual;

  always_comb begin
    dual = trig_code[TRIG_W-1];
    base = base_mode_e'(trig_code[BASE_W-1:0]);
    unique case (base)
      MODE_FALL: qual = info.fall;
      MODE_RISE: qual = info.rise;
      MODE_LOW:  qual = changed & ~info.now_high;
      MODE_HIGH: qual = changed & info.now_high;
      default:   qual = 1'b0;
    endcase
    if (dual) qual = changed;
    hit = int_en & qual;
  end
endmodule

// File: rtl/pin_sticky_flag.sv
module pin_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_in,
  input  logic clr_in,
  output logic flag_q,
  output logic pulse_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= set_in;
      if (set_in) flag_q <= 1'b1;
      else if (clr_in) flag_q <= 1'b0;
    end
  end

  // R9: the flag is sticky without a clear
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_in) |=> flag_q);
  // R10: a clear with no set empties the flag
  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_in && !set_in) |=> !flag_q);
  // R11: a set beats a same-cycle clear
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    set_in |=> (flag_q && pulse_q));
  // R12: a pulse never shows without the flag
  assert_pulse_implies_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> flag_q);
endmodule

// File: rtl/pin_irq_trigger.sv
module pin_irq_trigger
  import pin_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_en,
  input  logic [TRIG_W-1:0] trig_code,
  input  logic              sample_strobe,
  input  logic              sample_level,
  input  logic              status_clr,
  output logic              irq_status,
  output logic              irq_set_pulse
);
  edge_info_t info_w;
  logic       changed_w;
  logic       hit_w;

  pin_edge_track u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (sample_strobe),
    .level   (sample_level),
    .info    (info_w),
    .changed (changed_w)
  );

  pin_trig_decode u_dec (
    .int_en    (int_en),
    .trig_code (trig_code),
    .info      (info_w),
    .changed   (changed_w),
    .hit       (hit_w)
  );

  pin_sticky_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_in  (hit_w),
    .clr_in  (status_clr),
    .flag_q  (irq_status),
    .pulse_q (irq_set_pulse)
  );

  // R7: disabled pin never pulses
  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |=> !irq_set_pulse);
  // R8: no change means no event
  assert_no_change_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !changed_w |=> !irq_set_pulse);
  // R6: top code bit fires on every change
  assert_dual_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en && trig_code[TRIG_W-1] && changed_w) |=> irq_set_pulse);
  // R2: falling mode fires on a fall
  assert_fall_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en && trig_code == 3'b000 && info_w.fall) |=> irq_set_pulse);
  // R3: rising mode fires on a rise
  assert_rise_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en && trig_code == 3'b001 && info_w.rise) |=> irq_set_pulse);
endmodule

// File: tb/sim_pin_irq_trigger.sv
module sim_pin_irq_trigger;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       int_en = 1'b0;
  logic [2:0] trig_code = 3'b000;
  logic       sample_strobe = 1'b0;
  logic       sample_level = 1'b0;
  logic       status_clr = 1'b0;
  logic       irq_status;
  logic       irq_set_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [1:0] exp_q[$];
  string      req_q[$];
  logic       m_prev = 1'b0;
  logic       m_stat = 1'b0;

  always #5 clk = ~clk;

  pin_irq_trigger u0 (
    .clk(clk), .rst_n(rst_n), .int_en(int_en), .trig_code(trig_code),
    .sample_strobe(sample_strobe), .sample_level(sample_level),
    .status_clr(status_clr), .irq_status(irq_status),
    .irq_set_pulse(irq_set_pulse)
  );

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {status,pulse} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(input logic v, input logic lv, input logic en,
                      input logic [2:0] code, input logic clr, input string req);
    logic chg, rise, fall, hit;
    @(negedge clk);
    sample_strobe = v; sample_level = lv; int_en = en;
    trig_code = code; status_clr = clr;
    chg  = v && (lv != m_prev);
    rise = chg && lv;
    fall = chg && !lv;
    if (code[2]) hit = chg;
    else case (code[1:0])
      2'b00:   hit = fall;
      2'b01:   hit = rise;
      2'b10:   hit = chg && !lv;
      default: hit = chg && lv;
    endcase
    hit = hit && en;
    if (hit) m_stat = 1'b1;
    else if (clr) m_stat = 1'b0;
    if (v) m_prev = lv;
    exp_q.push_back({m_stat, hit});
    req_q.push_back(req);
  endtask

  // Monitor: after each edge, pops and compares.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [1:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check({irq_status, irq_set_pulse}, e, r);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check({irq_status, irq_set_pulse}, 2'b00, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check({irq_status, irq_set_pulse}, 2'b00, "R1 after release");

    step(1, 1, 1, 3'b001, 0, "R1 first strobe rises from reset value");
    step(0, 1, 1, 3'b001, 0, "R9 flag holds, pulse ends");
    step(0, 1, 1, 3'b001, 0, "R9 flag still held");
    step(0, 1, 1, 3'b001, 1, "R10 clear set flag");
    step(0, 1, 1, 3'b001, 1, "R10 clear already-clear flag");
    step(1, 0, 1, 3'b001, 0, "R3 fall ignored in rising mode");
    step(1, 1, 1, 3'b001, 0, "R3 rise fires");
    step(0, 1, 1, 3'b000, 1, "R10 clear");
    step(1, 1, 1, 3'b000, 0, "R8 unchanged strobe quiet");
    step(1, 0, 1, 3'b000, 0, "R2 fall fires");
    step(0, 0, 1, 3'b000, 1, "R10 clear");
    step(1, 1, 1, 3'b000, 0, "R2 rise ignored in falling mode");
    step(1, 1, 1, 3'b011, 0, "R8 level-high on unchanged high stays quiet");
    step(1, 0, 1, 3'b011, 0, "R5 change to low does not fire level-high");
    step(1, 1, 1, 3'b011, 0, "R5 change to high fires");
    step(0, 1, 1, 3'b010, 1, "R10 clear");
    step(1, 0, 1, 3'b010, 0, "R4 change to low fires");
    step(0, 0, 1, 3'b010, 1, "R10 clear");
    step(1, 0, 1, 3'b010, 0, "R8 level-low on unchanged low stays quiet");
    step(1, 1, 1, 3'b010, 0, "R4 change to high does not fire");
    step(1, 0, 1, 3'b100, 0, "R6 dual 100 fall");
    step(1, 1, 1, 3'b101, 0, "R12 dual 101 rise pulses on set flag");
    step(1, 0, 1, 3'b110, 0, "R6 dual 110 fall");
    step(1, 1, 1, 3'b111, 0, "R6 dual 111 rise");
    step(0, 1, 1, 3'b111, 0, "R12 pulse lasts one cycle");
    step(1, 0, 1, 3'b111, 1, "R11 set wins over same-cycle clear");
    step(0, 0, 1, 3'b111, 1, "R10 clear");
    step(1, 1, 0, 3'b111, 0, "R7 disabled rise quiet");
    step(1, 0, 0, 3'b111, 0, "R7 disabled fall quiet");
    step(1, 1, 0, 3'b001, 0, "R13 strobe stored while disabled");
    step(1, 1, 1, 3'b001, 0, "R13 enabled repeat of stored high quiet");
    step(1, 0, 1, 3'b000, 0, "R13 fall from stored high fires");
    step(0, 1, 1, 3'b111, 1, "R8 level move without strobe quiet");
    step(0, 0, 1, 3'b111, 0, "R8 no strobe stays quiet");
    step(0, 0, 0, 3'b000, 0, "R9 idle");
    repeat (3) @(posedge clk);
    #4;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule